// File: doc/BRIEF.md
# Memory-based radix-2 FFT engine

The block computes a 512-point complex discrete Fourier transform over one frame of 16-bit audio samples, working in place on an on-chip data store. Samples are loaded through a write stream that files each sample at the bit-reversed position of its time index. A start pulse then runs nine decimation-in-time stages. In every clock cycle two butterfly lanes each read a pair of complex words, multiply the lower word by a twiddle factor taken from a table of half a period, and write both results back. When all stages are done, the bins can be read out in natural order through a request/response port.

Each butterfly halves its results, so the transform carries an overall scale of 1/512 and cannot grow beyond the input range. With 48 kHz input, bin k is centred on k × 93.75 Hz. The write stream and the read request channel both use valid/ready. Each one is ready only while the engine is idle, so a source has to hold a beat while the engine computes. The read response has no ready: it appears exactly one cycle after the request was accepted, and the receiver has to take it then.

Top module: `fft_core`

## Requirements
- R1: After reset, s_ready and rq_ready are 1 and done and rs_valid are 0.
- R2: A sample beat is taken on a rising edge where s_valid and s_ready are both 1. Sample s_data with time index s_idx becomes the real part of that point, and its imaginary part is 0. While a transform runs, s_ready is 0 and a beat offered on s_valid changes nothing in the result.
- R3: A start pulse seen while idle begins a transform. done is high for exactly one cycle, the 1152nd cycle after the edge that took start, and s_ready returns to 1 in that same cycle.
- R4: A start pulse seen while a transform runs is ignored. The done timing is unchanged, and no second done pulse follows.
- R5: After done, bin k (0..511) holds (1/512)·Σ x[n]·e^(−j2πkn/512). Real and imaginary parts are each within ±8 LSB of that value for inputs within ±16000.
- R6: Exact cases. An impulse of 16384 at n=0 gives 32+0j in every bin. A constant 16384 at every n gives 16384+0j in bin 0 and 0+0j in every other bin.
- R7: A read request is taken on an edge with rq_valid and rq_ready both 1. rs_valid is 1 in the next cycle only, and rs_data carries bin rq_addr, with the real part in bits [15:0] and the imaginary part in bits [31:16], both two's complement. rq_ready is 0 while a transform runs, and a request offered then gets no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample beat valid |
| s_ready | output | 1 | Engine idle, sample beat can be taken |
| s_idx | input | 9 | Time index of the sample |
| s_data | input | 16 | Signed sample value |
| start | input | 1 | Pulse to begin a transform |
| done | output | 1 | One-cycle pulse when the result is ready |
| rq_valid | input | 1 | Bin read request valid |
| rq_ready | output | 1 | Read request can be taken |
| rq_addr | input | 9 | Bin index to read |
| rs_valid | output | 1 | Read response valid |
| rs_data | output | 32 | Bin value, imaginary part above real part |

## Verification
done is due in the 1152nd cycle after the edge that took start. The bench counts falling edges from that point and requires done to appear first at count 1152 and to be low at the next sample. A read response is due one cycle after the request edge, so each read drives the request at a falling edge and samples rs_valid and rs_data at the next falling edge. The beats offered during a busy transform (a sample, a read and a second start) sit at fixed counts within the run, and their lack of effect is judged from the exact DC result and from the done count.

// File: rtl/fft_pkg.sv
package fft_pkg;
  localparam int DW = 16;
  localparam int TW = 17;

  typedef struct packed {
    logic signed [DW-1:0] im;
    logic signed [DW-1:0] re;
  } cplx_t;

  localparam longint QS  = 64'd1073741824;
  localparam longint PIQ = 64'd3373259426;

  // sin(2*pi*m/n) scaled by 2^(TW-2), for m in [0, n/4], by Taylor series
  function automatic int qsin(int m, int n);
    longint x, term, sum;
    x = (PIQ * 2 * longint'(m)) / longint'(n);
    term = x;
    sum = x;
    for (int i = 1; i <= 7; i++) begin
      term = -((((term * x) / QS) * x) / QS) / longint'((2 * i) * (2 * i + 1));
      sum = sum + term;
    end
    return int'((sum * (64'd1 << (TW - 2)) + QS / 2) / QS);
  endfunction

  function automatic int tw_cos(int k, int n);
    if (k <= n / 4) return qsin(n / 4 - k, n);
    return -qsin(k - n / 4, n);
  endfunction

  function automatic int tw_sin(int k, int n);
    if (k <= n / 4) return qsin(k, n);
    return qsin(n / 2 - k, n);
  endfunction
endpackage

// File: rtl/fft_twiddle.sv
module fft_twiddle
  import fft_pkg::*;
#(
  parameter int LOG2N = 9,
  parameter int LANES = 2,
  localparam int N  = 1 << LOG2N,
  localparam int KW = LOG2N - 1
) (
  input  logic [KW-1:0]          k  [LANES],
  output logic signed [TW-1:0]   wr [LANES],
  output logic signed [TW-1:0]   wi [LANES]
);
  logic signed [TW-1:0] tab_re [N/2];
  logic signed [TW-1:0] tab_im [N/2];

  for (genvar g = 0; g < N / 2; g++) begin : g_tab
    localparam int CV = tw_cos(g, N);
    localparam int SV = tw_sin(g, N);
    assign tab_re[g] = TW'(CV);
    assign tab_im[g] = TW'(-SV);
  end

  for (genvar l = 0; l < LANES; l++) begin : g_port
    assign wr[l] = tab_re[k[l]];
    assign wi[l] = tab_im[k[l]];
  end
endmodule

// File: rtl/fft_seq.sv
module fft_seq #(
  parameter int LOG2N = 9,
  parameter int LANES = 2,
  localparam int N   = 1 << LOG2N,
  localparam int AW  = LOG2N,
  localparam int KW  = LOG2N - 1,
  localparam int SW  = $clog2(LOG2N),
  localparam int CYC = N / 2 / LANES,
  localparam int CW  = (CYC > 1) ? $clog2(CYC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] top_a [LANES],
  output logic [AW-1:0] bot_a [LANES],
  output logic [KW-1:0] tw_k  [LANES]
);
  logic [SW-1:0] stage;
  logic [CW-1:0] cyc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      stage <= '0;
      cyc   <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          stage <= '0;
          cyc   <= '0;
        end
      end else if (cyc == CW'(CYC - 1)) begin
        cyc <= '0;
        if (stage == SW'(LOG2N - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          stage <= stage + SW'(1);
        end
      end else begin
        cyc <= cyc + CW'(1);
      end
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [AW-1:0] j, lo, base;
    always_comb begin
      j    = AW'(int'(cyc) * LANES + l);
      lo   = j & ((AW'(1) << stage) - AW'(1));
      base = ((j >> stage) << (stage + SW'(1))) | lo;
    end
    assign top_a[l] = base;
    assign bot_a[l] = base | (AW'(1) << stage);
    assign tw_k[l]  = KW'(lo << (SW'(LOG2N - 1) - stage));
  end
endmodule

// File: rtl/fft_bfly.sv
module fft_bfly
  import fft_pkg::*;
(
  input  cplx_t                a,
  input  cplx_t                b,
  input  logic signed [TW-1:0] wr,
  input  logic signed [TW-1:0] wi,
  output cplx_t                x,
  output cplx_t                y
);
  localparam int PW = DW + TW + 1;

  logic signed [PW-1:0] ar, ai, pr, pi, xr, xi, yr, yi;
  logic unused_lsb;

  always_comb begin
    ar = PW'(a.re) <<< (TW - 2);
    ai = PW'(a.im) <<< (TW - 2);
    pr = PW'(b.re) * PW'(wr) - PW'(b.im) * PW'(wi);
    pi = PW'(b.re) * PW'(wi) + PW'(b.im) * PW'(wr);
    xr = ar + pr;
    xi = ai + pi;
    yr = ar - pr;
    yi = ai - pi;
  end

  assign x.re = xr[DW+TW-2:TW-1];
  assign x.im = xi[DW+TW-2:TW-1];
  assign y.re = yr[DW+TW-2:TW-1];
  assign y.im = yi[DW+TW-2:TW-1];

  assign unused_lsb = ^{xr[TW-2:0], xi[TW-2:0], yr[TW-2:0], yi[TW-2:0],
                        xr[PW-1:DW+TW-1], xi[PW-1:DW+TW-1],
                        yr[PW-1:DW+TW-1], yi[PW-1:DW+TW-1]};
endmodule

// File: rtl/fft_core.sv
module fft_core
  import fft_pkg::*;
#(
  parameter int LOG2N = 9,
  parameter int LANES = 2,
  localparam int N  = 1 << LOG2N,
  localparam int AW = LOG2N,
  localparam int KW = LOG2N - 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [AW-1:0] s_idx,
  input  logic [DW-1:0] s_data,
  input  logic          start,
  output logic          done,
  input  logic          rq_valid,
  output logic          rq_ready,
  input  logic [AW-1:0] rq_addr,
  output logic          rs_valid,
  output logic [2*DW-1:0] rs_data
);
  logic                 busy;
  logic [AW-1:0]        top_a [LANES];
  logic [AW-1:0]        bot_a [LANES];
  logic [KW-1:0]        tw_k  [LANES];
  logic signed [TW-1:0] wr    [LANES];
  logic signed [TW-1:0] wi    [LANES];
  cplx_t                ba    [LANES];
  cplx_t                bb    [LANES];
  cplx_t                bx    [LANES];
  cplx_t                by    [LANES];
  cplx_t                mem   [N];
  logic [AW-1:0]        rev_idx;

  fft_seq #(.LOG2N(LOG2N), .LANES(LANES)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .top_a(top_a), .bot_a(bot_a), .tw_k(tw_k)
  );

  fft_twiddle #(.LOG2N(LOG2N), .LANES(LANES)) u_tw (
    .k(tw_k), .wr(wr), .wi(wi)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_bf
    assign ba[l] = mem[top_a[l]];
    assign bb[l] = mem[bot_a[l]];
    fft_bfly u_bf (
      .a(ba[l]), .b(bb[l]), .wr(wr[l]), .wi(wi[l]), .x(bx[l]), .y(by[l])
    );
  end

  always_comb begin
    for (int i = 0; i < AW; i++) rev_idx[i] = s_idx[AW-1-i];
  end

  assign s_ready  = !busy;
  assign rq_ready = !busy;

  always_ff @(posedge clk) begin
    if (busy) begin
      for (int l = 0; l < LANES; l++) begin
        mem[top_a[l]] <= bx[l];
        mem[bot_a[l]] <= by[l];
      end
    end else if (s_valid) begin
      mem[rev_idx] <= '{im: '0, re: s_data};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rs_valid <= 1'b0;
      rs_data  <= '0;
    end else begin
      rs_valid <= rq_valid && !busy;
      if (rq_valid && !busy) rs_data <= mem[rq_addr];
    end
  end
endmodule

// File: rtl/fft_check.sv
module fft_check #(
  parameter int LOG2N = 9,
  parameter int LANES = 2,
  localparam int N     = 1 << LOG2N,
  localparam int AW    = LOG2N,
  localparam int TOTAL = LOG2N * (N / 2) / LANES
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          done,
  input logic          s_ready,
  input logic          rq_valid,
  input logic          rq_ready,
  input logic          rs_valid,
  input logic          busy,
  input logic [AW-1:0] top_a [LANES],
  input logic [AW-1:0] bot_a [LANES]
);
  logic        run;
  logic [15:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (start && s_ready) begin
      run <= 1'b1;
      cnt <= '0;
    end else if (done) begin
      run <= 1'b0;
    end else if (run) begin
      cnt <= cnt + 16'd1;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> !done && !rs_valid && s_ready && rq_ready);

  a_r2_take_start_blocks_samples: assert property (@(posedge clk) disable iff (!rst_n)
    start && s_ready |=> !s_ready && !rq_ready);

  a_r3_done_latency: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> run && cnt == 16'(TOTAL) && s_ready);

  a_r3_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r4_restart_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    start && !s_ready && run && cnt < 16'(TOTAL - 1) |=> !s_ready && !done);

  a_r7_response_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rq_valid && rq_ready |=> rs_valid);

  a_r7_no_response: assert property (@(posedge clk) disable iff (!rst_n)
    !(rq_valid && rq_ready) |=> !rs_valid);

  if (LANES > 1) begin : g_disj
    a_r5_lanes_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> top_a[0] != top_a[1] && bot_a[0] != bot_a[1] &&
               top_a[0] != bot_a[1] && top_a[1] != bot_a[0]);
  end
endmodule

bind fft_core fft_check #(.LOG2N(LOG2N), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done), .s_ready(s_ready),
  .rq_valid(rq_valid), .rq_ready(rq_ready), .rs_valid(rs_valid),
  .busy(busy), .top_a(top_a), .bot_a(bot_a)
);

// File: tb/fft_core_test.sv
module fft_core_test;
  localparam int CLK_NS = 10;
  localparam int NPT = 512;
  localparam int LAT = 1152;
  localparam real PI2 = 6.283185307179586;

  logic clk = 0, rst_n = 0;
  logic s_valid = 0, start = 0, rq_valid = 0;
  logic [8:0] s_idx = 0, rq_addr = 0;
  logic [15:0] s_data = 0;
  logic s_ready, done, rq_ready, rs_valid;
  logic [31:0] rs_data;

  int tests = 0, fails = 0;
  int xs [NPT];

  always #(CLK_NS / 2) clk = ~clk;

  fft_core uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_idx(s_idx), .s_data(s_data), .start(start), .done(done),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_addr(rq_addr),
    .rs_valid(rs_valid), .rs_data(rs_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic real ref_re(int k);
    real s = 0.0;
    for (int n = 0; n < NPT; n++) s += xs[n] * $cos(PI2 * ((k * n) % NPT) / NPT);
    return s / NPT;
  endfunction

  function automatic real ref_im(int k);
    real s = 0.0;
    for (int n = 0; n < NPT; n++) s -= xs[n] * $sin(PI2 * ((k * n) % NPT) / NPT);
    return s / NPT;
  endfunction

  task automatic load_frame();
    for (int n = 0; n < NPT; n++) begin
      @(negedge clk);
      s_valid = 1; s_idx = 9'(n); s_data = 16'(xs[n]);
    end
    @(negedge clk);
    s_valid = 0;
  endtask

  task automatic read_bin(input int k, output int re, output int im);
    @(negedge clk);
    rq_valid = 1; rq_addr = 9'(k);
    @(negedge clk);
    rq_valid = 0;
    chk(rs_valid === 1'b1, "R7", "rs_valid one cycle after request", int'(rs_valid), 1);
    re = int'($signed(rs_data[15:0]));
    im = int'($signed(rs_data[31:16]));
  endtask

  task automatic run_frame(input bit disturb);
    int cnt = 0;
    int extra = 0;
    bit seen = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    while (!seen && cnt < LAT + 100) begin
      @(negedge clk);
      cnt++;
      if (disturb) begin
        if (cnt == 300) begin
          chk(s_ready == 1'b0, "R2", "s_ready while busy", int'(s_ready), 0);
          s_valid = 1; s_idx = 9'd5; s_data = 16'hFC18;
        end
        if (cnt == 301) s_valid = 0;
        if (cnt == 400) begin
          chk(rq_ready == 1'b0, "R7", "rq_ready while busy", int'(rq_ready), 0);
          rq_valid = 1; rq_addr = 9'd0;
        end
        if (cnt == 401) begin
          chk(rs_valid == 1'b0, "R7", "no response while busy", int'(rs_valid), 0);
          rq_valid = 0;
        end
        if (cnt == 500) start = 1;
        if (cnt == 501) start = 0;
      end
      if (done) seen = 1;
    end
    chk(cnt == LAT, disturb ? "R4" : "R3", "done latency", cnt, LAT);
    chk(s_ready == 1'b1, "R3", "s_ready with done", int'(s_ready), 1);
    @(negedge clk);
    chk(done == 1'b0, "R3", "done width", int'(done), 0);
    if (disturb) begin
      repeat (200) begin
        @(negedge clk);
        if (done) extra++;
      end
      chk(extra == 0, "R4", "extra done pulses", extra, 0);
    end
  endtask

  task automatic check_approx(input int k);
    int re, im, er, ei;
    read_bin(k, re, im);
    er = $rtoi(ref_re(k) + ((ref_re(k) >= 0) ? 0.5 : -0.5));
    ei = $rtoi(ref_im(k) + ((ref_im(k) >= 0) ? 0.5 : -0.5));
    chk(re - er <= 8 && er - re <= 8, "R5", $sformatf("bin %0d real", k), re, er);
    chk(im - ei <= 8 && ei - im <= 8, "R5", $sformatf("bin %0d imag", k), im, ei);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int re, im, bad;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(s_ready === 1'b1 && rq_ready === 1'b1, "R1", "ready after reset",
        int'({s_ready, rq_ready}), 3);
    chk(done === 1'b0 && rs_valid === 1'b0, "R1", "outputs low in reset",
        int'({done, rs_valid}), 0);
    rst_n = 1;
    @(negedge clk);
    chk(done === 1'b0 && rs_valid === 1'b0 && s_ready === 1'b1, "R1", "idle after reset",
        int'({done, rs_valid, s_ready}), 1);

    // impulse
    for (int n = 0; n < NPT; n++) xs[n] = (n == 0) ? 16384 : 0;
    load_frame();
    run_frame(0);
    bad = 0;
    for (int k = 0; k < NPT; k++) begin
      read_bin(k, re, im);
      if (re != 32 || im != 0) bad++;
    end
    chk(bad == 0, "R6", "impulse bins not 32+0j", bad, 0);

    // constant, with busy-time sample, read and start offered
    for (int n = 0; n < NPT; n++) xs[n] = 16384;
    load_frame();
    run_frame(1);
    read_bin(0, re, im);
    chk(re == 16384 && im == 0, "R6", "dc bin 0 real", re, 16384);
    bad = 0;
    for (int k = 1; k < NPT; k++) begin
      read_bin(k, re, im);
      if (re != 0 || im != 0) bad++;
    end
    chk(bad == 0, "R2", "dc bins nonzero after ignored write", bad, 0);

    // tone at bin 8
    for (int n = 0; n < NPT; n++) xs[n] = $rtoi(12000.0 * $cos(PI2 * ((8 * n) % NPT) / NPT));
    load_frame();
    run_frame(0);
    for (int k = 0; k < 12; k++) check_approx(k);
    check_approx(504);
    check_approx(511);

    // random frames
    for (int f = 0; f < 3; f++) begin
      for (int n = 0; n < NPT; n++) xs[n] = int'($urandom_range(32000)) - 16000;
      load_frame();
      run_frame(0);
      check_approx(0);
      check_approx(256);
      check_approx(511);
      for (int t = 0; t < 10; t++) check_approx(int'($urandom_range(511)));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule